// File: doc/BRIEF.md
# Idle-Stripping Clock Compensation Elastic Buffer

This block sits on a receive lane behind the character decoder. Decoded characters, each an 8-bit code plus a K flag, arrive on the recovered write clock. They leave on a read clock that runs at a slightly different frequency, up to 200 ppm apart in the worst case. Storage is eight entries. Idle characters (/K/, /A/ and /R/) are never written into storage. Instead, each stored character carries one bit that says whether an idle position followed it. The read side then produces idles itself, as many as it needs.

The two clock rates are absorbed at the idle positions. If the write side sees the buffer nearly full, it discards the idle position that is about to be recorded. If the read side reaches an idle position while the buffer is nearly empty, it keeps sending /R/ until enough entries have arrived. A source-select input tells the block where its read clock comes from. With the local reference or lane A's recovered clock, compensation is active. With the lane's own recovered clock, both clocks run at the same rate, so compensation is off and each idle position comes out as it was recorded. Two sticky flags, one in each clock domain, record overflow and underflow.

Top module: `ccf_elastic`

## Requirements
- R1: Every non-idle character appears on the read stream in write order with its code and K flag unchanged. Non-idle characters are any code with K=0, and any K=1 code other than 0xBC, 0x7C and 0x1C. At most 8 entries are held.
- R2: The codes 0xBC (/K/), 0x7C (/A/) and 0x1C (/R/) with K=1 are treated as idles and are never stored. The only idle the read stream ever carries is the generated /R/ (0x1C, K=1). 0xBC with K=0 is ordinary data.
- R3: A character that must be committed while all 8 entries are occupied is lost, and `wr_overflow` (write domain) goes to 1 and stays there until reset.
- R4: Suppose the last character read had no idle position recorded after it, and the buffer is then empty when the next character is needed. In that case `rd_underflow` (read domain) goes to 1 and stays there, and /R/ is sent for that cycle.
- R5: Between two consecutive data characters, the read stream carries at least one /R/ if an idle position between them was recorded. It carries none if no idle position was recorded and no underflow occurred.
- R6: In a compensating mode, when the read side reaches an idle position and sees fewer than 2 entries, it sends another /R/ in place of the next entry. It repeats this each cycle until 2 or more entries are present.
- R7: In a compensating mode, the first idle after a data character decides whether its idle position is recorded. If the write side then sees more than 6 entries, the position is discarded.
- R8: `clk_src` encoding: 0 = local reference, 1 = the lane's own recovered clock, 2 = lane A's recovered clock, 3 = treated as 0. Codes 0, 2 and 3 compensate. Code 1 neither discards nor inserts, so each recorded idle position gives exactly one /R/ unless the buffer is empty.
- R9: Each domain has a synchronous, active-high reset. While in reset, `rd_valid`, `wr_overflow` and `rd_underflow` are 0. After reset, `rd_valid` is 1 and /R/ is sent until data is available. `clk_src` is sampled during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | Write character present |
| wr_data | input | 8 | Write character code |
| wr_k | input | 1 | Write character K flag |
| wr_overflow | output | 1 | Sticky overflow flag, write domain |
| rd_clk | input | 1 | Read clock, chosen externally as selected by `clk_src` |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| clk_src | input | 2 | Read clock source select, held steady outside reset |
| rd_valid | output | 1 | Read character present (1 every cycle after reset) |
| rd_data | output | 8 | Read character code |
| rd_k | output | 1 | Read character K flag |
| rd_underflow | output | 1 | Sticky underflow flag, read domain |

## Verification
The first stream runs on equal clocks and mixes runs of 1 to 5 data characters, K=1 data and 0xBC with K=0, separated by rotating /K/, /A/ and /R/ idles. It shows that idles are recognised, stripped and regenerated without disturbing order. A dense stream of 15 data characters per idle, with the read clock slower than the write clock, separates the two modes. In a compensating mode, idle positions must disappear and no overflow may occur. With the lane's own clock, every position must come back exactly. Short runs with a much faster read clock tell whether gap insertion is present: in a compensating mode the underflow flag must stay clear, while with the lane's own clock it must be set. Long runs with no idles force overflow and underflow.

// File: rtl/ccf_pkg.sv
package ccf_pkg;

    typedef struct packed {
        logic       k;
        logic [7:0] code;
    } ccf_char_t;

    typedef struct packed {
        logic      gap_after;
        ccf_char_t ch;
    } ccf_entry_t;

    typedef enum logic [1:0] {
        SRC_LOCAL_REF = 2'd0,
        SRC_OWN_RECOV = 2'd1,
        SRC_LANE_A    = 2'd2,
        SRC_SPARE     = 2'd3
    } ccf_src_e;

    localparam logic [7:0] CODE_SYNC  = 8'hBC;
    localparam logic [7:0] CODE_ALIGN = 8'h7C;
    localparam logic [7:0] CODE_REPL  = 8'h1C;

    localparam ccf_char_t FILL_CHAR = '{k: 1'b1, code: CODE_REPL};

    localparam int ENTRY_W = $bits(ccf_entry_t);

    function automatic logic is_idle(ccf_char_t c);
        return c.k && (c.code == CODE_SYNC || c.code == CODE_ALIGN || c.code == CODE_REPL);
    endfunction

    function automatic logic comp_on(ccf_src_e s);
        return s != SRC_OWN_RECOV;
    endfunction

    function automatic logic [15:0] bin2gray(logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [15:0] gray2bin(logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ccf_sync.sv
module ccf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ccf_mem.sv
module ccf_mem #(
    parameter int DEPTH = 8,
    parameter int W     = 10,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ccf_wr_ctl.sv
module ccf_wr_ctl
    import ccf_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int HI_MARK = 6,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  ccf_src_e      src,
    input  logic          in_valid,
    input  ccf_char_t     in_ch,
    input  logic [AW:0]   rptr_gray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output ccf_entry_t    mem_wdata,
    output logic [AW:0]   wptr_gray,
    output logic [AW:0]   occ,
    output logic          full,
    output logic          commit,
    output logic          ovf
);
    ccf_src_e    src_q;
    logic [AW:0] wbin;
    logic [AW:0] wbin_nxt;
    logic [AW:0] rbin;
    logic [15:0] rbin_wide;
    logic [15:0] gray_wide;
    ccf_char_t   staged;
    logic        staged_v;
    logic        idle_in;
    logic        keep_gap;

    always_comb begin
        rbin_wide = gray2bin(16'(rptr_gray_s));
        rbin      = rbin_wide[AW:0];
        occ       = wbin - rbin;
        full      = (occ == (AW+1)'(DEPTH));
        idle_in   = in_valid && is_idle(in_ch);
        commit    = in_valid && staged_v;
        keep_gap  = !comp_on(src_q) || (occ <= (AW+1)'(HI_MARK));
        mem_we    = commit && !full;
        mem_waddr = wbin[AW-1:0];
        mem_wdata = '{gap_after: idle_in && keep_gap, ch: staged};
        wbin_nxt  = wbin + (AW+1)'(mem_we);
        gray_wide = bin2gray(16'(wbin_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= src;
            wbin      <= '0;
            wptr_gray <= '0;
            staged    <= FILL_CHAR;
            staged_v  <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            wbin      <= wbin_nxt;
            wptr_gray <= gray_wide[AW:0];
            if (commit && full) begin
                ovf <= 1'b1;
            end
            if (in_valid && !idle_in) begin
                staged   <= in_ch;
                staged_v <= 1'b1;
            end else if (commit) begin
                staged_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccf_rd_ctl.sv
module ccf_rd_ctl
    import ccf_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int LO_MARK = 2,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  ccf_src_e      src,
    input  logic [AW:0]   wptr_gray_s,
    input  ccf_entry_t    head,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_gray,
    output logic [AW:0]   occ,
    output logic          out_valid,
    output ccf_char_t     out_ch,
    output logic          unf
);
    ccf_src_e    src_q;
    logic [AW:0] rbin;
    logic [AW:0] rbin_nxt;
    logic [AW:0] wbin;
    logic [15:0] wbin_wide;
    logic [15:0] gray_wide;
    logic        empty;
    logic        gap_pend;
    logic        in_run;
    logic        pop;
    logic        hold_gap;

    always_comb begin
        wbin_wide = gray2bin(16'(wptr_gray_s));
        wbin      = wbin_wide[AW:0];
        occ       = wbin - rbin;
        empty     = (occ == '0);
        pop       = !gap_pend && !empty;
        hold_gap  = comp_on(src_q) && (occ < (AW+1)'(LO_MARK));
        raddr     = rbin[AW-1:0];
        rbin_nxt  = rbin + (AW+1)'(pop);
        gray_wide = bin2gray(16'(rbin_nxt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= src;
            rbin      <= '0;
            rptr_gray <= '0;
            gap_pend  <= 1'b0;
            in_run    <= 1'b0;
            unf       <= 1'b0;
            out_valid <= 1'b0;
            out_ch    <= FILL_CHAR;
        end else begin
            out_valid <= 1'b1;
            rbin      <= rbin_nxt;
            rptr_gray <= gray_wide[AW:0];
            if (gap_pend) begin
                out_ch <= FILL_CHAR;
                if (!hold_gap) begin
                    gap_pend <= 1'b0;
                end
            end else if (empty) begin
                out_ch <= FILL_CHAR;
                if (in_run) begin
                    unf <= 1'b1;
                end
                in_run <= 1'b0;
            end else begin
                out_ch   <= head.ch;
                gap_pend <= head.gap_after;
                in_run   <= !head.gap_after;
            end
        end
    end
endmodule

// File: rtl/ccf_elastic.sv
module ccf_elastic
    import ccf_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int HI_MARK = 6,
    parameter int LO_MARK = 2
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       wr_k,
    output logic       wr_overflow,
    input  logic       rd_clk,
    input  logic       rd_rst,
    input  logic [1:0] clk_src,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_k,
    output logic       rd_underflow
);
    localparam int AW = $clog2(DEPTH);

    ccf_src_e      src;
    ccf_char_t     in_ch;
    ccf_char_t     out_ch;
    ccf_entry_t    wr_entry;
    ccf_entry_t    rd_entry;
    logic [ENTRY_W-1:0] rd_bits;
    logic          mem_we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wptr_gray;
    logic [AW:0]   rptr_gray;
    logic [AW:0]   wptr_gray_s;
    logic [AW:0]   rptr_gray_s;
    logic [AW:0]   wr_occ;
    logic [AW:0]   rd_occ;
    logic          wr_full;
    logic          wr_commit;

    assign src      = ccf_src_e'(clk_src);
    assign in_ch    = '{k: wr_k, code: wr_data};
    assign rd_entry = ccf_entry_t'(rd_bits);
    assign rd_data  = out_ch.code;
    assign rd_k     = out_ch.k;

    ccf_wr_ctl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .AW(AW)) u_wr (
        .clk         (wr_clk),
        .rst         (wr_rst),
        .src         (src),
        .in_valid    (wr_valid),
        .in_ch       (in_ch),
        .rptr_gray_s (rptr_gray_s),
        .mem_we      (mem_we),
        .mem_waddr   (waddr),
        .mem_wdata   (wr_entry),
        .wptr_gray   (wptr_gray),
        .occ         (wr_occ),
        .full        (wr_full),
        .commit      (wr_commit),
        .ovf         (wr_overflow)
    );

    ccf_mem #(.DEPTH(DEPTH), .W(ENTRY_W), .AW(AW)) u_mem (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_entry),
        .raddr (raddr),
        .rdata (rd_bits)
    );

    ccf_sync #(.W(AW+1)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wptr_gray),
        .q   (wptr_gray_s)
    );

    ccf_sync #(.W(AW+1)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rptr_gray),
        .q   (rptr_gray_s)
    );

    ccf_rd_ctl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .AW(AW)) u_rd (
        .clk         (rd_clk),
        .rst         (rd_rst),
        .src         (src),
        .wptr_gray_s (wptr_gray_s),
        .head        (rd_entry),
        .raddr       (raddr),
        .rptr_gray   (rptr_gray),
        .occ         (rd_occ),
        .out_valid   (rd_valid),
        .out_ch      (out_ch),
        .unf         (rd_underflow)
    );
endmodule

// File: rtl/ccf_elastic_chk.sv
module ccf_elastic_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic        wr_clk,
    input logic        wr_rst,
    input logic        rd_clk,
    input logic        rd_rst,
    input logic        wr_overflow,
    input logic        wr_full,
    input logic        wr_commit,
    input logic [AW:0] wr_occ,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic        rd_k,
    input logic        rd_underflow
);
    // R1: the write view never counts more entries than storage holds
    assert_occ_bound_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_occ <= (AW+1)'(DEPTH));

    // R2: received idle codes never reach the read stream
    assert_no_stored_idle_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && rd_k) |-> (rd_data != 8'hBC && rd_data != 8'h7C));

    // R3: committing into a full buffer raises the flag
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_commit && wr_full) |=> wr_overflow);

    // R3: overflow flag is sticky
    assert_ovf_sticky_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_overflow |=> wr_overflow);

    // R4: underflow flag is sticky
    assert_unf_sticky_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_underflow |=> rd_underflow);

    // R9: reset clears the read side outputs
    assert_reset_clear_R9: assert property (@(posedge rd_clk)
        rd_rst |=> (!rd_valid && !rd_underflow));
endmodule

bind ccf_elastic ccf_elastic_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst       (wr_rst),
    .rd_clk       (rd_clk),
    .rd_rst       (rd_rst),
    .wr_overflow  (wr_overflow),
    .wr_full      (wr_full),
    .wr_commit    (wr_commit),
    .wr_occ       (wr_occ),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_k         (rd_k),
    .rd_underflow (rd_underflow)
);

// File: tb/tb_ccf_elastic.sv
`timescale 1ns/1ps
module tb_ccf_elastic;

    realtime wr_half = 5.0;
    realtime rd_half = 5.0;
    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    always #(wr_half) wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    logic       wr_rst = 1'b1;
    logic       rd_rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h1C;
    logic       wr_k = 1'b1;
    logic [1:0] clk_src = 2'd0;
    logic       wr_overflow;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_k;
    logic       rd_underflow;

    ccf_elastic dut (
        .wr_clk       (wr_clk),
        .wr_rst       (wr_rst),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_k         (wr_k),
        .wr_overflow  (wr_overflow),
        .rd_clk       (rd_clk),
        .rd_rst       (rd_rst),
        .clk_src      (clk_src),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_k         (rd_k),
        .rd_underflow (rd_underflow)
    );

    typedef struct {
        logic [7:0] code;
        logic       k;
        bit         gap;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   sb_on = 1'b0;
    bit   strict = 1'b0;
    bit   seen_idle = 1'b0;
    bit   gap_flag = 1'b1;
    int   drops = 0;
    int   idle_rot = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard as characters come out
    always @(negedge rd_clk) begin
        if (sb_on && rd_valid) begin
            if (rd_k && rd_data == 8'h1C) begin
                seen_idle = 1'b1;
            end else if (rd_k && (rd_data == 8'hBC || rd_data == 8'h7C)) begin
                check(1'b0, "R2", "raw idle code on output", int'(rd_data), 'h1C);
            end else if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected character", int'({rd_k, rd_data}), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({rd_k, rd_data} == {e.k, e.code}, "R1", "character order",
                      int'({rd_k, rd_data}), int'({e.k, e.code}));
                if (strict)
                    check(seen_idle == e.gap, "R8", "idle position reproduced",
                          int'(seen_idle), int'(e.gap));
                else if (seen_idle && !e.gap)
                    check(1'b0, "R5", "idle inserted inside a run", 1, 0);
                if (e.gap && !seen_idle) drops++;
                seen_idle = 1'b0;
            end
        end
    end

    task automatic put_data(input logic [7:0] code, input logic k);
        exp_t e;
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = code;
        wr_k     = k;
        e.code = code;
        e.k    = k;
        e.gap  = gap_flag;
        sb.push_back(e);
        gap_flag = 1'b0;
    endtask

    task automatic put_idles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_valid = 1'b1;
            wr_k     = 1'b1;
            case (idle_rot % 3)
                0: wr_data = 8'hBC;
                1: wr_data = 8'h7C;
                default: wr_data = 8'h1C;
            endcase
            idle_rot++;
            gap_flag = 1'b1;
        end
    endtask

    task automatic do_reset(input logic [1:0] src, input realtime wh, input realtime rh,
                            input bit sb_enable, input bit strict_mode);
        sb_on    = 1'b0;
        wr_rst   = 1'b1;
        rd_rst   = 1'b1;
        wr_valid = 1'b1;
        wr_data  = 8'h1C;
        wr_k     = 1'b1;
        clk_src  = src;
        wr_half  = wh;
        rd_half  = rh;
        repeat (5) @(negedge wr_clk);
        repeat (5) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
        check(wr_overflow == 1'b0, "R9", "overflow in reset", int'(wr_overflow), 0);
        check(rd_underflow == 1'b0, "R9", "underflow in reset", int'(rd_underflow), 0);
        sb.delete();
        seen_idle = 1'b0;
        gap_flag  = 1'b1;
        drops     = 0;
        strict    = strict_mode;
        sb_on     = sb_enable;
        wr_rst    = 1'b0;
        @(negedge rd_clk);
        rd_rst    = 1'b0;
        repeat (3) @(negedge rd_clk);
        check(rd_valid == 1'b1 && rd_k == 1'b1 && rd_data == 8'h1C, "R9",
              "fill after reset", int'({rd_valid, rd_k, rd_data}), 'h31C);
    endtask

    task automatic drain(input string req);
        put_idles(80);
        check(sb.size() == 0, req, "undelivered characters", sb.size(), 0);
    endtask

    task automatic mixed_stream(input int groups);
        for (int g = 0; g < groups; g++) begin
            for (int j = 0; j <= g % 5; j++) begin
                if (j == 1)      put_data(8'hBC, 1'b0);
                else if (j == 3) put_data(8'hFB, 1'b1);
                else             put_data(8'((g * 37 + j * 11 + 5) & 8'hFF), 1'b0);
            end
            put_idles((g % 3) + 1);
        end
    endtask

    task automatic dense_stream(input int groups);
        for (int g = 0; g < groups; g++) begin
            for (int j = 0; j < 15; j++) put_data(8'((g * 15 + j) & 8'hFF), 1'b0);
            put_idles(1);
        end
    endtask

    task automatic short_runs(input int groups);
        for (int g = 0; g < groups; g++) begin
            for (int j = 0; j < 4; j++) put_data(8'((g * 4 + j + 64) & 8'hFF), 1'b0);
            put_idles(1);
        end
    endtask

    initial begin
        // T1: equal clocks, mixed runs and all three idle codes (R1 R2 R5)
        do_reset(2'd0, 5.0, 5.0, 1'b1, 1'b0);
        mixed_stream(12);
        drain("R1");
        check(rd_underflow == 1'b0, "R5", "no underflow on equal clocks", int'(rd_underflow), 0);
        check(wr_overflow == 1'b0, "R3", "no overflow on equal clocks", int'(wr_overflow), 0);

        // T2: read slightly faster, lane A source (R5 R8)
        do_reset(2'd2, 5.0, 4.999, 1'b1, 1'b0);
        mixed_stream(40);
        drain("R5");
        check(rd_underflow == 1'b0, "R4", "no underflow with small offset", int'(rd_underflow), 0);

        // T3: dense data, read slower, compensating mode drops idles (R7)
        do_reset(2'd0, 5.0, 5.2, 1'b1, 1'b0);
        dense_stream(30);
        drain("R7");
        check(drops > 0, "R7", "idle positions discarded", drops, 1);
        check(wr_overflow == 1'b0, "R7", "drop prevents overflow", int'(wr_overflow), 0);

        // T4: same stream, own recovered clock: every position kept (R8)
        do_reset(2'd1, 5.0, 5.2, 1'b1, 1'b1);
        dense_stream(4);
        drain("R8");
        check(wr_overflow == 1'b0, "R8", "no overflow in short dense run", int'(wr_overflow), 0);

        // T5: short runs, much faster read, spare code compensates by inserting (R6 R8)
        do_reset(2'd3, 5.0, 4.5, 1'b1, 1'b0);
        short_runs(25);
        drain("R6");
        check(rd_underflow == 1'b0, "R6", "insertion avoids underflow", int'(rd_underflow), 0);

        // T6: same with own recovered clock: no insertion, so underflow (R8 R4)
        do_reset(2'd1, 5.0, 4.5, 1'b0, 1'b0);
        short_runs(25);
        put_idles(40);
        check(rd_underflow == 1'b1, "R8", "no insertion in own-clock mode", int'(rd_underflow), 1);

        // T7: long run with no idles into a slow reader (R3)
        do_reset(2'd0, 5.0, 12.0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) put_data(8'(i), 1'b0);
        put_idles(10);
        check(wr_overflow == 1'b1, "R3", "overflow flag set", int'(wr_overflow), 1);
        put_idles(40);
        check(wr_overflow == 1'b1, "R3", "overflow flag sticky", int'(wr_overflow), 1);

        // T8: long run with no idles into a fast reader (R4)
        do_reset(2'd0, 5.0, 2.5, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) put_data(8'(i + 100), 1'b0);
        put_idles(20);
        check(rd_underflow == 1'b1, "R4", "underflow flag set", int'(rd_underflow), 1);
        @(negedge rd_clk);
        check(rd_k == 1'b1 && rd_data == 8'h1C, "R4", "fill after underflow",
              int'({rd_k, rd_data}), 'h11C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule